// File: doc/BRIEF.md
# Per-Tile Palette Attribute Override

This block sits on the video memory read path of a tile-based picture generator. It watches the rendering fetches that the video controller issues. Most tiles share one attribute byte among a 2x2 group. With this block, each tile can pick its own palette instead.

When the feature is on, the block keeps the 10-bit offset of the most recent name-table fetch. When an attribute fetch follows, the normal memory data is dropped. In its place the block returns a byte that holds one 2-bit palette number copied into every 2-bit field. That palette number comes from one of two small expansion stores, indexed by the kept offset. Because every field carries the same value, the video controller gets the right palette whichever quadrant shift it applies. The override byte appears combinationally, in the same cycle as the attribute fetch address.

The CPU loads the expansion stores through a write-only window that repeats across the top quarter of its address space. It sets the enable bit and the screen-arrangement mode through one control register. The mode decides which of the two stores an attribute fetch reads.

Top module: `tile_palette_override`

## Requirements
- R1: After reset the control register holds enable 0 and mode 0 (vertical), so an attribute fetch returns `mem_rdata` unchanged.
- R2: A rendering fetch (`vid_rd`=1, `vid_render`=1) with `vid_addr` >= 0x2000 and `vid_addr[9:0]` < 0x3C0 is a name-table fetch. While enabled, its `vid_addr[9:0]` is captured at the clock edge. Its own read data passes through unchanged.
- R3: A rendering fetch with `vid_addr` >= 0x2000 and `vid_addr[9:0]` >= 0x3C0 is an attribute fetch. While enabled, `vid_rdata` in that same cycle equals `{p,p,p,p}`, where p is the 2-bit entry stored at the captured offset in the selected bank.
- R4: While the enable bit is 0, attribute fetches return `mem_rdata` and name-table fetches leave the captured offset unchanged.
- R5: The bank read by an attribute fetch is set by the mode: 0 takes `vid_addr[10]`, 1 takes `vid_addr[11]`, 2 always takes bank 0, and 3 always takes bank 1.
- R6: A CPU write with `cpu_addr[15:14]`=2'b11 stores `cpu_wdata[1:0]` in bank `cpu_addr[10]` at index `cpu_addr[9:0]`. Address bits 13:11 are ignored, so the 2 KB window repeats through 0xC000-0xFFFF.
- R7: A CPU write with `cpu_addr[15:14]`=2'b10 and `cpu_addr[3:0]`=0xA loads the control register: mode from `cpu_wdata[1:0]`, enable from `cpu_wdata[2]`. Address bits 13:4 are ignored. A write with any other low nibble leaves the control register unchanged.
- R8: Non-rendering fetches (`vid_render`=0) and fetches below 0x2000 return `mem_rdata` and do not change the captured offset.
- R9: The captured offset changes only on an enabled name-table fetch. Several attribute fetches in a row all use the same offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| vid_rd | input | 1 | Video memory read strobe |
| vid_render | input | 1 | Read belongs to the rendering fetch sequence |
| vid_addr | input | 14 | Video memory address |
| mem_rdata | input | 8 | Data from the normal video memory path |
| vid_rdata | output | 8 | Data returned to the video controller |

## Verification
A wrong captured offset or a wrong bank choice shows up as the wrong palette byte on the very next attribute fetch. Each such case is therefore checked right after the name-table fetch or mode write that should have set it. A control register that loads at the wrong address shows up as a pass-through or a change of bank on the next attribute fetch. A store write that lands at the wrong index only shows up when that index is captured later, so the bench reads back every entry it writes, in each bank and through the repeated window. A latch that follows disabled or non-rendering name-table fetches is caught by re-enabling, or by a later rendering attribute fetch that still has to return the older palette.

// File: rtl/tpo_pkg.sv
package tpo_pkg;

   typedef enum logic [1:0] {
      MIR_VERT  = 2'd0,
      MIR_HORZ  = 2'd1,
      MIR_ONE_A = 2'd2,
      MIR_ONE_B = 2'd3
   } mir_mode_e;

   typedef struct packed {
      logic      en;
      mir_mode_e mode;
   } tpo_ctrl_t;

   localparam int CTRL_MODE_LSB = 0;
   localparam int CTRL_EN_BIT   = 2;

endpackage

// File: rtl/tpo_fetch_classify.sv
module tpo_fetch_classify #(
   parameter int VADDR_W  = 14,
   parameter int IDX_W    = 10,
   parameter int NT_BASE  = 'h2000,
   parameter int NT_LIMIT = 'h3C0
) (
   input  logic               vid_rd,
   input  logic               vid_render,
   input  logic [VADDR_W-1:0] vid_addr,
   output logic               is_name,
   output logic               is_attr,
   output logic [IDX_W-1:0]   idx
);
   if (VADDR_W <= IDX_W) begin : g_bad_width
      $error("tpo_fetch_classify: VADDR_W must exceed IDX_W");
   end
   if (NT_LIMIT >= (1 << IDX_W)) begin : g_bad_limit
      $error("tpo_fetch_classify: NT_LIMIT must fit within IDX_W bits");
   end

   localparam logic [VADDR_W-1:0] BASE_V  = VADDR_W'(NT_BASE);
   localparam logic [IDX_W-1:0]   LIMIT_V = IDX_W'(NT_LIMIT);

   logic in_region;
   logic render_rd;

   always_comb begin
      render_rd = vid_rd && vid_render;
      in_region = vid_addr >= BASE_V;
      idx       = vid_addr[IDX_W-1:0];
      is_name   = render_rd && in_region && (idx <  LIMIT_V);
      is_attr   = render_rd && in_region && (idx >= LIMIT_V);
   end
endmodule

// File: rtl/tpo_bank_select.sv
module tpo_bank_select
   import tpo_pkg::*;
#(
   parameter int VADDR_W = 14,
   parameter int VERT_BIT = 10,
   parameter int HORZ_BIT = 11
) (
   input  mir_mode_e          mode,
   input  logic [VADDR_W-1:0] vid_addr,
   output logic               bank
);
   if (VERT_BIT >= VADDR_W || HORZ_BIT >= VADDR_W) begin : g_bad_bits
      $error("tpo_bank_select: bank bits must lie inside the address");
   end

   always_comb begin
      unique case (mode)
         MIR_VERT:  bank = vid_addr[VERT_BIT];
         MIR_HORZ:  bank = vid_addr[HORZ_BIT];
         MIR_ONE_A: bank = 1'b0;
         MIR_ONE_B: bank = 1'b1;
         default:   bank = 1'b0;
      endcase
   end
endmodule

// File: rtl/tpo_cpu_decode.sv
module tpo_cpu_decode
   import tpo_pkg::*;
#(
   parameter int          CADDR_W  = 16,
   parameter int          DATA_W   = 8,
   parameter int          IDX_W    = 10,
   parameter int          PAL_W    = 2,
   parameter logic [3:0]  CTRL_SEL = 4'hA
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_we,
   input  logic [CADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output tpo_ctrl_t          ctrl,
   output logic               ram_we,
   output logic               ram_bank,
   output logic [IDX_W-1:0]   ram_idx,
   output logic [PAL_W-1:0]   ram_wdata
);
   if (CADDR_W < IDX_W + 3) begin : g_bad_caddr
      $error("tpo_cpu_decode: CADDR_W too small for the store window");
   end
   if (DATA_W <= CTRL_EN_BIT || DATA_W < PAL_W) begin : g_bad_data
      $error("tpo_cpu_decode: DATA_W too small for the control fields");
   end

   localparam int TOP = CADDR_W - 1;

   logic ctrl_hit;
   logic unused_addr;
   logic unused_data;

   assign ctrl_hit  = cpu_we && (cpu_addr[TOP -: 2] == 2'b10) && (cpu_addr[3:0] == CTRL_SEL);
   assign ram_we    = cpu_we && (cpu_addr[TOP -: 2] == 2'b11);
   assign ram_bank  = cpu_addr[IDX_W];
   assign ram_idx   = cpu_addr[IDX_W-1:0];
   assign ram_wdata = cpu_wdata[PAL_W-1:0];

   assign unused_addr = ^cpu_addr[TOP-2:IDX_W+1];
   assign unused_data = ^cpu_wdata[DATA_W-1:CTRL_EN_BIT+1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl.en   <= 1'b0;
         ctrl.mode <= MIR_VERT;
      end else if (ctrl_hit) begin
         ctrl.en   <= cpu_wdata[CTRL_EN_BIT];
         ctrl.mode <= mir_mode_e'(cpu_wdata[CTRL_MODE_LSB +: 2]);
      end
   end

   a_r7_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_hit |=> (ctrl.en == $past(cpu_wdata[CTRL_EN_BIT]))
                && (ctrl.mode == mir_mode_e'($past(cpu_wdata[1:0]))));

   a_r7_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_hit |=> $stable(ctrl));

   a_r6_r7_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_hit && ram_we));
endmodule

// File: rtl/tpo_attr_ram.sv
module tpo_attr_ram #(
   parameter int IDX_W = 10,
   parameter int PAL_W = 2,
   parameter int NBANKS = 2
) (
   input  logic             clk,
   input  logic             we,
   input  logic             wbank,
   input  logic [IDX_W-1:0] widx,
   input  logic [PAL_W-1:0] wdata,
   input  logic             rbank,
   input  logic [IDX_W-1:0] ridx,
   output logic [PAL_W-1:0] rdata
);
   if (NBANKS != 2) begin : g_bad_banks
      $error("tpo_attr_ram: bank select is one bit, NBANKS must be 2");
   end

   localparam int DEPTH = 1 << IDX_W;

   logic [PAL_W-1:0] bank_q [NBANKS];

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic [PAL_W-1:0] store [DEPTH];
      logic             hit;

      assign hit = we && (wbank == b[0]);

      always_ff @(posedge clk) begin
         if (hit) store[widx] <= wdata;
      end

      assign bank_q[b] = store[ridx];
   end

   assign rdata = bank_q[rbank];
endmodule

// File: rtl/tile_palette_override.sv
module tile_palette_override
   import tpo_pkg::*;
#(
   parameter int          CADDR_W  = 16,
   parameter int          VADDR_W  = 14,
   parameter int          DATA_W   = 8,
   parameter int          IDX_W    = 10,
   parameter int          PAL_W    = 2,
   parameter int          NT_BASE  = 'h2000,
   parameter int          NT_LIMIT = 'h3C0,
   parameter logic [3:0]  CTRL_SEL = 4'hA
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_we,
   input  logic [CADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   input  logic               vid_rd,
   input  logic               vid_render,
   input  logic [VADDR_W-1:0] vid_addr,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic [DATA_W-1:0]  vid_rdata
);
   if (DATA_W % PAL_W != 0) begin : g_bad_rep
      $error("tile_palette_override: DATA_W must be a multiple of PAL_W");
   end

   localparam int REP = DATA_W / PAL_W;

   tpo_ctrl_t        ctrl;
   logic             ram_we;
   logic             ram_bank;
   logic [IDX_W-1:0] ram_idx;
   logic [PAL_W-1:0] ram_wdata;
   logic             is_name;
   logic             is_attr;
   logic [IDX_W-1:0] cls_idx;
   logic             rd_bank;
   logic [IDX_W-1:0] nt_idx;
   logic [PAL_W-1:0] pal;
   logic [DATA_W-1:0] ovr_byte;
   logic             ovr;
   logic             capture;

   tpo_cpu_decode #(
      .CADDR_W (CADDR_W),
      .DATA_W  (DATA_W),
      .IDX_W   (IDX_W),
      .PAL_W   (PAL_W),
      .CTRL_SEL(CTRL_SEL)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_we   (cpu_we),
      .cpu_addr (cpu_addr),
      .cpu_wdata(cpu_wdata),
      .ctrl     (ctrl),
      .ram_we   (ram_we),
      .ram_bank (ram_bank),
      .ram_idx  (ram_idx),
      .ram_wdata(ram_wdata)
   );

   tpo_fetch_classify #(
      .VADDR_W (VADDR_W),
      .IDX_W   (IDX_W),
      .NT_BASE (NT_BASE),
      .NT_LIMIT(NT_LIMIT)
   ) u_cls (
      .vid_rd    (vid_rd),
      .vid_render(vid_render),
      .vid_addr  (vid_addr),
      .is_name   (is_name),
      .is_attr   (is_attr),
      .idx       (cls_idx)
   );

   tpo_bank_select #(
      .VADDR_W(VADDR_W)
   ) u_bank (
      .mode    (ctrl.mode),
      .vid_addr(vid_addr),
      .bank    (rd_bank)
   );

   tpo_attr_ram #(
      .IDX_W (IDX_W),
      .PAL_W (PAL_W),
      .NBANKS(2)
   ) u_ram (
      .clk  (clk),
      .we   (ram_we),
      .wbank(ram_bank),
      .widx (ram_idx),
      .wdata(ram_wdata),
      .rbank(rd_bank),
      .ridx (nt_idx),
      .rdata(pal)
   );

   assign capture = ctrl.en && is_name;

   always_ff @(posedge clk) begin
      if (!rst_n)       nt_idx <= '0;
      else if (capture) nt_idx <= cls_idx;
   end

   for (genvar g = 0; g < REP; g++) begin : g_rep
      assign ovr_byte[g*PAL_W +: PAL_W] = pal;
   end

   assign ovr       = ctrl.en && is_attr;
   assign vid_rdata = ovr ? ovr_byte : mem_rdata;

   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.en && is_name) |=> (nt_idx == $past(vid_addr[IDX_W-1:0])));

   a_r9_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl.en && is_name) |=> $stable(nt_idx));

   a_r2_kind_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(is_name && is_attr));

   a_r8_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (!vid_rd || !vid_render) |-> (vid_rdata == mem_rdata));

   a_r4_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.en |-> (vid_rdata == mem_rdata));

   a_r3_name_passes: assert property (@(posedge clk) disable iff (!rst_n)
      is_name |-> (vid_rdata == mem_rdata));
endmodule

// File: tb/tile_palette_override_test.sv
module tile_palette_override_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        vid_rd = 1'b0;
   logic        vid_render = 1'b0;
   logic [13:0] vid_addr = '0;
   logic [7:0]  mem_rdata = '0;
   logic [7:0]  vid_rdata;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tile_palette_override uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .vid_rd    (vid_rd),
      .vid_render(vid_render),
      .vid_addr  (vid_addr),
      .mem_rdata (mem_rdata),
      .vid_rdata (vid_rdata)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_we = 1'b0;
   endtask

   task automatic fetch(input logic [13:0] a, input logic r, input logic [7:0] m,
                        output logic [7:0] res);
      @(negedge clk);
      vid_rd = 1'b1; vid_render = r; vid_addr = a; mem_rdata = m;
      #1 res = vid_rdata;
      @(posedge clk);
      #1 vid_rd = 1'b0; vid_render = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] r;
      fetch(14'h23C0, 1'b1, 8'h5A, r);
      chk("R1 attribute passes after reset", r, 8'h5A);
   endtask

   task automatic t_fill;
      cpu_write(16'hC005, 8'hFE);   // bank0[5] = 2
      cpu_write(16'hC405, 8'h01);   // bank1[5] = 1
      cpu_write(16'hFC07, 8'h03);   // bank1[7] = 3 through repeated window
      cpu_write(16'hC007, 8'h01);   // bank0[7] = 1
      cpu_write(16'hC3BF, 8'h02);   // bank0[0x3BF] = 2
   endtask

   task automatic t_basic;
      logic [7:0] r;
      cpu_write(16'h800A, 8'h06);   // enable, single bank 0
      fetch(14'h2005, 1'b1, 8'h11, r);
      chk("R2 name-table data passes", r, 8'h11);
      fetch(14'h23C0, 1'b1, 8'h33, r);
      chk("R3 override byte", r, 8'hAA);
      fetch(14'h23C8, 1'b1, 8'h33, r);
      chk("R9 offset held for second attribute", r, 8'hAA);
   endtask

   task automatic t_modes;
      logic [7:0] r;
      cpu_write(16'h800A, 8'h07);   // single bank 1
      fetch(14'h23C0, 1'b1, 8'h00, r);
      chk("R5 mode3 bank1", r, 8'h55);
      cpu_write(16'h800A, 8'h04);   // vertical
      fetch(14'h27C0, 1'b1, 8'h00, r);
      chk("R5 mode0 bit10 set", r, 8'h55);
      fetch(14'h2BC0, 1'b1, 8'h00, r);
      chk("R5 mode0 bit11 only", r, 8'hAA);
      cpu_write(16'h800A, 8'h05);   // horizontal
      fetch(14'h2BC0, 1'b1, 8'h00, r);
      chk("R5 mode1 bit11 set", r, 8'h55);
      fetch(14'h27C0, 1'b1, 8'h00, r);
      chk("R5 mode1 bit10 only", r, 8'hAA);
   endtask

   task automatic t_mirror;
      logic [7:0] r;
      cpu_write(16'hE805, 8'h03);   // bank0[5] = 3, bits 13:11 differ
      cpu_write(16'h800A, 8'h06);
      fetch(14'h23C0, 1'b1, 8'h00, r);
      chk("R6 repeated window write", r, 8'hFF);
   endtask

   task automatic t_nonrender;
      logic [7:0] r;
      fetch(14'h2007, 1'b0, 8'h21, r);
      chk("R8 non-rendering name-table passes", r, 8'h21);
      fetch(14'h23C0, 1'b0, 8'h12, r);
      chk("R8 non-rendering attribute passes", r, 8'h12);
      fetch(14'h0007, 1'b1, 8'h44, r);
      chk("R8 low address passes", r, 8'h44);
      fetch(14'h23C0, 1'b1, 8'h00, r);
      chk("R8 offset not moved", r, 8'hFF);
   endtask

   task automatic t_capture;
      logic [7:0] r;
      fetch(14'h2407, 1'b1, 8'h77, r);
      chk("R2 name-table passes", r, 8'h77);
      fetch(14'h23C0, 1'b1, 8'h00, r);
      chk("R2 new offset bank0", r, 8'h55);
      cpu_write(16'h800A, 8'h07);
      fetch(14'h23C0, 1'b1, 8'h00, r);
      chk("R6 bank1 index7", r, 8'hFF);
   endtask

   task automatic t_disable;
      logic [7:0] r;
      cpu_write(16'h800A, 8'h02);   // disabled, single bank 0
      fetch(14'h23C0, 1'b1, 8'h9C, r);
      chk("R4 disabled attribute passes", r, 8'h9C);
      fetch(14'h2005, 1'b1, 8'h00, r);
      cpu_write(16'h800A, 8'h06);
      fetch(14'h23C0, 1'b1, 8'h00, r);
      chk("R4 disabled fetch did not capture", r, 8'h55);
   endtask

   task automatic t_ctrl_decode;
      logic [7:0] r;
      cpu_write(16'h800B, 8'h03);
      fetch(14'h23C0, 1'b1, 8'h00, r);
      chk("R7 other nibble ignored", r, 8'h55);
      cpu_write(16'hA00A, 8'h07);   // repeated control address, single bank 1
      fetch(14'h23C0, 1'b1, 8'h00, r);
      chk("R7 repeated control address", r, 8'hFF);
      cpu_write(16'hA00A, 8'h03);   // disable
      fetch(14'h23C0, 1'b1, 8'hC3, r);
      chk("R7 enable bit cleared", r, 8'hC3);
   endtask

   task automatic t_boundary;
      logic [7:0] r;
      cpu_write(16'h800A, 8'h06);
      fetch(14'h23BF, 1'b1, 8'h66, r);
      chk("R2 last name-table offset passes", r, 8'h66);
      fetch(14'h23FF, 1'b1, 8'h00, r);
      chk("R3 first-limit capture override", r, 8'hAA);
      fetch(14'h1FC0, 1'b1, 8'h39, r);
      chk("R8 below base not attribute", r, 8'h39);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_fill;
      t_basic;
      t_modes;
      t_mirror;
      t_nonrender;
      t_capture;
      t_disable;
      t_ctrl_decode;
      t_boundary;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=hung expected=complete");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule